// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Length

The block turns one character at a time into an asynchronous serial frame on a single line. It advances on a bit-rate enable, `tick_en`. In 16X mode every bit lasts sixteen enabled cycles. In 1X mode every bit lasts one enabled cycle. A frame has these parts in order:

- a low start bit;
- 5 to 8 data bits, least significant first;
- an optional parity bit;
- a high stop period.

In 16X mode the stop period can be set in sixteenths of a bit.

A producer offers a character on `wr_valid`/`wr_data`. The character is taken in any cycle where `ready` is high. All frame settings are captured together with the character. Software can also hold `brk_req` to send a break. During a break the line stays low for whole frame-length intervals. A one-cycle `brk_done` pulse marks the end of each interval, so software can count the break characters it has sent.

Top module: `async_tx_frac`

## Requirements
- R1: After reset, and whenever `busy` is low, `txd` is high. After reset `ready` is high and `busy` and `brk_done` are low.
- R2: A character is taken on a rising edge where `ready` and `wr_valid` are both high. From the next cycle on, `busy` is high and `txd` drives the frame: a start bit at 0, then 5 + `cfg_len` data bits from bit 0 upward (`cfg_len` 00=5 bits, 01=6, 10=7, 11=8). The frame advances only on cycles with `tick_en` high. Each bit lasts 16 such cycles when `cfg_x1`=0.
- R3: `cfg_par` 00 sends no parity bit. 01 sends even parity over the data bits sent. 10 sends odd parity. 11 sends the value of `cfg_fixed`. The parity bit comes right after the last data bit and lasts one bit time.
- R4: In 16X mode the stop period is high for `cfg_stop`+1 enabled cycles. This gives 1/16 to 2 bit times. `busy` falls right after the last of those cycles.
- R5: When `cfg_x1`=1, every start, data and parity bit lasts one enabled cycle. The stop period lasts max(1, (`cfg_stop`+9)/16) enabled cycles, using integer division.
- R6: From acceptance until the frame ends, `ready` is low. A `wr_valid` during that time is dropped: it does not change the frame in progress and does not start a later one.
- R7: Settings sampled at acceptance govern the whole frame. Changes to `cfg_*` while `busy` is high have no effect on it.
- R8: When `brk_req` is high while idle, a break starts. This takes priority over `wr_valid`, which is not taken. During the break, `txd` is low for frame-length intervals set by the current settings. A one-cycle `brk_done` pulse follows each interval. Intervals repeat while `brk_req` stays high. The break ends with the interval in progress once `brk_req` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Bit-rate enable (16X or 1X of the bit rate) |
| cfg_x1 | input | 1 | 1 = one enable per bit, 0 = sixteen |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_par | input | 2 | Parity mode: none, even, odd, fixed |
| cfg_fixed | input | 1 | Parity value used in fixed mode |
| cfg_stop | input | 5 | Stop length code in sixteenths, minus one |
| wr_valid | input | 1 | Character offered |
| wr_data | input | 8 | Character, bit 0 sent first |
| brk_req | input | 1 | Hold high to send break characters |
| txd | output | 1 | Serial line, high when idle |
| ready | output | 1 | Next character can be taken this cycle |
| busy | output | 1 | A frame or break interval is in progress |
| brk_done | output | 1 | One-cycle pulse at the end of each break interval |

## Verification
Some properties are checked by assertions on every cycle:

- the idle line is high;
- a taken character produces a low start bit on the next cycle;
- the captured settings hold steady through a frame;
- the sub-bit counter never passes its segment limit;
- a frame ends only at the close of its stop period;
- `brk_done` never lasts more than one cycle.

Other behaviour can only be shown by the bench's scenarios. These are the exact bit order, the parity values, the stop-length rounding in 1X mode, and the tick counts of whole frames and break intervals. The bench also shows that writes and setting changes during a frame leave it untouched, and that a break takes priority over a character offered in the same cycle.

// File: rtl/atx_pkg.sv
package atx_pkg;
  parameter int ATX_LEN_W  = 2;
  parameter int ATX_STOP_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } atx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_FIXED = 2'b11
  } atx_par_e;

  typedef struct packed {
    logic                  x1;
    logic [ATX_LEN_W-1:0]  len;
    atx_par_e              par;
    logic [ATX_STOP_W-1:0] stop;
  } atx_cfg_t;
endpackage

// File: rtl/atx_rst_sync.sv
module atx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/atx_parity.sv
module atx_parity
  import atx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5
) (
  input  logic [DATA_W-1:0]    data,
  input  logic [ATX_LEN_W-1:0] len_code,
  input  atx_par_e             mode,
  input  logic                 fixed_val,
  output logic                 par_bit
);
  logic [DATA_W-1:0] keep;
  logic              ones;

  for (genvar g = 0; g < DATA_W; g++) begin : g_keep
    assign keep[g] = (MIN_LEN + int'(len_code)) > g;
  end

  always_comb begin
    ones = ^(data & keep);
    case (mode)
      PAR_EVEN:  par_bit = ones;
      PAR_ODD:   par_bit = ~ones;
      PAR_FIXED: par_bit = fixed_val;
      default:   par_bit = 1'b1;
    endcase
  end
endmodule

// File: rtl/atx_bitclk.sv
module atx_bitclk #(
  parameter int OVS    = 16,
  parameter int STOP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              run,
  input  logic              in_stop,
  input  logic              x1,
  input  logic [STOP_W-1:0] stop_code,
  output logic              seg_end
);
  localparam int OVS_W = $clog2(OVS);
  localparam int CNT_W = (OVS_W > STOP_W) ? OVS_W : STOP_W;
  localparam int SUM_W = STOP_W + OVS_W;
  localparam int HALF  = OVS / 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic [SUM_W-1:0] stop_ticks, x1_raw, x1_bits;

  always_comb begin
    stop_ticks = SUM_W'(stop_code) + SUM_W'(1);
    x1_raw     = (stop_ticks + SUM_W'(HALF)) / SUM_W'(OVS);
    x1_bits    = (x1_raw == '0) ? SUM_W'(1) : x1_raw;
    if (x1) limit = in_stop ? CNT_W'(x1_bits - SUM_W'(1)) : '0;
    else    limit = in_stop ? CNT_W'(stop_code) : CNT_W'(OVS - 1);
    seg_end = run && tick_en && (cnt_q == limit);
    if (!run || seg_end) cnt_d = '0;
    else if (tick_en)    cnt_d = cnt_q + CNT_W'(1);
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  cnt_le_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/atx_seq.sv
module atx_seq
  import atx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  brk_req,
  input  atx_cfg_t              cfg_in,
  input  logic                  par_in,
  input  logic                  seg_end,
  output logic                  run,
  output logic                  in_stop,
  output logic                  lat_x1,
  output logic [ATX_STOP_W-1:0] lat_stop,
  output logic                  txd,
  output logic                  ready,
  output logic                  brk_done
);
  localparam int IDX_W = $clog2(DATA_W);

  atx_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_idx;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              brk_q, brk_d;
  atx_cfg_t          cfg_q, cfg_d;
  logic              line_q, line_d;
  logic              done_q, done_d;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    par_d    = par_q;
    brk_d    = brk_q;
    cfg_d    = cfg_q;
    done_d   = 1'b0;
    last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_q.len);
    case (state_q)
      ST_IDLE: begin
        if (brk_req) begin
          state_d = ST_START;
          brk_d   = 1'b1;
          cfg_d   = cfg_in;
        end else if (wr_valid) begin
          state_d = ST_START;
          brk_d   = 1'b0;
          cfg_d   = cfg_in;
          sh_d    = wr_data;
          par_d   = par_in;
        end
      end
      ST_START: if (seg_end) begin
        state_d = ST_DATA;
        idx_d   = '0;
      end
      ST_DATA: if (seg_end) begin
        sh_d = sh_q >> 1;
        if (idx_q == last_idx) state_d = (cfg_q.par != PAR_NONE) ? ST_PAR : ST_STOP;
        else                   idx_d   = idx_q + IDX_W'(1);
      end
      ST_PAR: if (seg_end) state_d = ST_STOP;
      ST_STOP: if (seg_end) begin
        done_d = brk_q;
        if (brk_q && brk_req) state_d = ST_START;
        else begin
          state_d = ST_IDLE;
          brk_d   = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    case (state_d)
      ST_START: line_d = 1'b0;
      ST_DATA:  line_d = sh_d[0];
      ST_PAR:   line_d = par_d;
      default:  line_d = 1'b1;
    endcase
    if (brk_d) line_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      brk_q   <= 1'b0;
      cfg_q   <= '0;
      line_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      brk_q   <= brk_d;
      cfg_q   <= cfg_d;
      line_q  <= line_d;
      done_q  <= done_d;
    end
  end

  assign run      = (state_q != ST_IDLE);
  assign in_stop  = (state_q == ST_STOP);
  assign lat_x1   = cfg_q.x1;
  assign lat_stop = cfg_q.stop;
  assign txd      = line_q;
  assign ready    = (state_q == ST_IDLE) && !brk_req;
  assign brk_done = done_q;

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> txd);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wr_valid) |=> (run && !txd));
  // R6
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(in_stop && seg_end)) |=> run);
  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cfg_q));
  // R8
  brk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |=> !brk_done);
endmodule

// File: rtl/async_tx_frac.sv
module async_tx_frac
  import atx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int MIN_LEN = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  cfg_x1,
  input  logic [ATX_LEN_W-1:0]  cfg_len,
  input  logic [1:0]            cfg_par,
  input  logic                  cfg_fixed,
  input  logic [ATX_STOP_W-1:0] cfg_stop,
  input  logic                  wr_valid,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  brk_req,
  output logic                  txd,
  output logic                  ready,
  output logic                  busy,
  output logic                  brk_done
);
  logic                  rst_s_n;
  logic                  par_w, seg_end_w, in_stop_w, lat_x1_w;
  logic [ATX_STOP_W-1:0] lat_stop_w;
  atx_cfg_t              cfg_in_w;

  assign cfg_in_w = '{x1: cfg_x1, len: cfg_len, par: atx_par_e'(cfg_par), stop: cfg_stop};

  atx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  atx_parity #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_par (
    .data      (wr_data),
    .len_code  (cfg_len),
    .mode      (atx_par_e'(cfg_par)),
    .fixed_val (cfg_fixed),
    .par_bit   (par_w)
  );

  atx_bitclk #(.OVS(OVS), .STOP_W(ATX_STOP_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tick_en   (tick_en),
    .run       (busy),
    .in_stop   (in_stop_w),
    .x1        (lat_x1_w),
    .stop_code (lat_stop_w),
    .seg_end   (seg_end_w)
  );

  atx_seq #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .brk_req  (brk_req),
    .cfg_in   (cfg_in_w),
    .par_in   (par_w),
    .seg_end  (seg_end_w),
    .run      (busy),
    .in_stop  (in_stop_w),
    .lat_x1   (lat_x1_w),
    .lat_stop (lat_stop_w),
    .txd      (txd),
    .ready    (ready),
    .brk_done (brk_done)
  );
endmodule

// File: tb/async_tx_frac_test.sv
module async_tx_frac_test;
  localparam int REC_MAX = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       cfg_x1 = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_par = 2'd0;
  logic       cfg_fixed = 1'b0;
  logic [4:0] cfg_stop = 5'd15;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       brk_req = 1'b0;
  logic       txd, ready, busy, brk_done;

  int nchk = 0;
  int nerr = 0;
  int nrec = 0;
  int npulse = 0;
  int tick_div = 0;
  bit tick_off = 1'b0;
  bit rec [0:REC_MAX-1];

  async_tx_frac uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_x1(cfg_x1), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_fixed(cfg_fixed), .cfg_stop(cfg_stop), .wr_valid(wr_valid),
    .wr_data(wr_data), .brk_req(brk_req), .txd(txd), .ready(ready), .busy(busy),
    .brk_done(brk_done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (tick_off)           tick_en = 1'b0;
    else if (tick_div == 0) tick_en = 1'b1;
    else                    tick_en = (($urandom % tick_div) == 0);
  end

  always @(negedge clk) begin
    if (rst_n && tick_en && busy) begin
      if (nrec < REC_MAX) rec[nrec] = txd;
      nrec = nrec + 1;
    end
    if (brk_done) npulse = npulse + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nerr = nerr + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stop_ticks_f(int x1, int sc);
    int n;
    int b;
    n = sc + 1;
    if (x1 == 0) return n;
    b = (n + 8) / 16;
    if (b < 1) b = 1;
    return b;
  endfunction

  function automatic int frame_ticks_f(int x1, int lc, int pc, int sc);
    int bt;
    int nb;
    bt = (x1 != 0) ? 1 : 16;
    nb = 1 + 5 + lc + ((pc != 0) ? 1 : 0);
    return nb * bt + stop_ticks_f(x1, sc);
  endfunction

  function automatic bit line_f(int t, logic [7:0] d, int x1, int lc, int pc, int fx);
    int bt;
    int s;
    int nd;
    bit p;
    bt = (x1 != 0) ? 1 : 16;
    s  = t / bt;
    nd = 5 + lc;
    if (s == 0) return 1'b0;
    if (s <= nd) return d[s-1];
    if (pc != 0 && s == nd + 1) begin
      p = 1'b0;
      for (int i = 0; i < nd; i++) p = p ^ d[i];
      case (pc)
        1:       return p;
        2:       return ~p;
        default: return fx[0];
      endcase
    end
    return 1'b1;
  endfunction

  // poke: write and change settings mid-frame (R6, R7); stall: stop ticks after start (R2)
  task automatic send_frame(input logic [7:0] d, input bit poke, input bit stall);
    int x1, lc, pc, fx, sc, exp_n, bad, lim;
    x1 = cfg_x1; lc = cfg_len; pc = cfg_par; fx = cfg_fixed; sc = cfg_stop;
    @(negedge clk);
    while (!ready) @(negedge clk);
    @(posedge clk); #1;
    nrec = 0; wr_data = d; wr_valid = 1'b1;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    if (stall) begin
      @(negedge clk);
      tick_off = 1'b1;
      repeat (20) @(negedge clk);
      chk(busy && !txd, "R2 held start bit without ticks", int'({busy, txd}), 2);
      tick_off = 1'b0;
    end
    if (poke) begin
      cfg_x1 = ~cfg_x1; cfg_len = cfg_len + 2'd1; cfg_par = cfg_par + 2'd1;
      cfg_fixed = ~cfg_fixed; cfg_stop = cfg_stop + 5'd9;
      wr_data = ~d; wr_valid = 1'b1;
      @(negedge clk);
      chk(!ready, "R6 ready low during frame", int'(ready), 0);
      @(posedge clk); #1;
      wr_valid = 1'b0;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    exp_n = frame_ticks_f(x1, lc, pc, sc);
    chk(nrec == exp_n, (x1 != 0) ? "R5 frame tick count" : "R4 frame tick count", nrec, exp_n);
    bad = 0;
    lim = (nrec < exp_n) ? nrec : exp_n;
    for (int t = 0; t < lim; t++)
      if (rec[t] != line_f(t, d, x1, lc, pc, fx)) bad = bad + 1;
    chk(bad == 0, "R2 R3 frame bit values", bad, 0);
    if (poke) begin
      chk(bad == 0 && nrec == exp_n, "R7 settings change ignored", bad, 0);
      repeat (4) @(negedge clk);
      chk(!busy, "R6 dropped write started no frame", int'(busy), 0);
      cfg_x1 = x1[0]; cfg_len = lc[1:0]; cfg_par = pc[1:0]; cfg_fixed = fx[0]; cfg_stop = sc[4:0];
    end
  endtask

  task automatic send_break(input int hold);
    int fr, zeros_bad;
    fr = frame_ticks_f(cfg_x1, cfg_len, cfg_par, cfg_stop);
    @(negedge clk);
    while (busy) @(negedge clk);
    @(posedge clk); #1;
    nrec = 0; npulse = 0; brk_req = 1'b1; wr_valid = 1'b1; wr_data = 8'hFF;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    repeat (hold) @(posedge clk);
    #1 brk_req = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    zeros_bad = 0;
    for (int t = 0; t < nrec && t < REC_MAX; t++) if (rec[t]) zeros_bad = zeros_bad + 1;
    chk(zeros_bad == 0, "R8 line low during break", zeros_bad, 0);
    chk(npulse >= 1, "R8 at least one break pulse", npulse, 1);
    chk(nrec == npulse * fr, "R8 ticks per break interval", nrec, npulse * fr);
    chk(!busy && txd, "R8 priority over write, idle after break", int'({busy, txd}), 1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);
    chk(ready === 1'b1, "R1 reset ready", int'(ready), 1);
    chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    chk(brk_done === 1'b0, "R1 reset brk_done", int'(brk_done), 0);

    // directed corners
    cfg_x1 = 0; cfg_len = 0; cfg_par = 0; cfg_stop = 0;  send_frame(8'hA5, 0, 0);
    cfg_len = 3; cfg_par = 2; cfg_stop = 31;             send_frame(8'h3C, 0, 1);
    cfg_par = 3; cfg_fixed = 0; cfg_stop = 7;            send_frame(8'hFF, 0, 0);
    cfg_par = 1; cfg_len = 2; cfg_stop = 15;             send_frame(8'h81, 1, 0);
    cfg_x1 = 1; cfg_par = 3; cfg_fixed = 1; cfg_stop = 6; send_frame(8'h00, 0, 0);
    cfg_stop = 7;  cfg_par = 0;                          send_frame(8'h55, 0, 0);
    cfg_stop = 23; cfg_par = 2; cfg_len = 1;             send_frame(8'h2D, 0, 0);
    tick_div = 3;
    cfg_stop = 31; cfg_len = 3;                          send_frame(8'hC3, 1, 0);

    // random frames
    for (int k = 0; k < 30; k++) begin
      tick_div  = $urandom % 4;
      cfg_x1    = $urandom % 2;
      cfg_len   = 2'($urandom % 4);
      cfg_par   = 2'($urandom % 4);
      cfg_fixed = $urandom % 2;
      cfg_stop  = 5'($urandom % 32);
      send_frame(8'($urandom % 256), (k % 5) == 0, 1'b0);
    end

    // breaks
    tick_div = 0; cfg_x1 = 0; cfg_len = 0; cfg_par = 0; cfg_stop = 0; send_break(200);
    tick_div = 2; cfg_x1 = 1; cfg_len = 3; cfg_par = 1; cfg_stop = 31; send_break(40);
    tick_div = 0; cfg_x1 = 0; cfg_len = 3; cfg_par = 3; cfg_stop = 31; send_break(5);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr = nerr + 1;
    nchk = nchk + 1;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule